// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the run of column addresses that the burst needs, one per clock cycle. The command supplies a start column, a burst length code and an ordering choice. The block then steps through the columns of the burst. For fixed lengths, the columns stay inside the aligned block whose size is the burst length. For a full-page burst, they wrap around all 256 columns of the open row.

A controller pulses `start_i` for one cycle with the command fields. From the next cycle on, the generator presents `col_o` with `valid_o` high, and it flags the final beat of a fixed-length burst on `last_o`. A full-page burst runs until `term_i` stops it or a new `start_i` replaces it. A new `start_i` always cuts off whatever burst is running.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: A `start_i` sampled high at a clock edge puts the first beat on the outputs right after that edge, with `col_o` equal to the sampled `start_col_i`. A new beat follows on every cycle after that.
- R3: With `btype_i` = 0 (sequential) and a fixed length BL, beat k shows the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The upper bits never change.
- R4: With `btype_i` = 1 (interleaved) and a fixed length BL, beat k shows the start column with its low log2(BL) bits replaced by (start low bits XOR k). The upper bits never change.
- R5: `blen_i` codes 0, 1, 2 and 3 select bursts of exactly 1, 2, 4 and 8 beats. After the last beat, `valid_o` drops unless a new start is sampled.
- R6: `blen_i` codes 4 to 7 select full page. Beat k is (start + k) mod 256, so column 255 is followed by 0. `btype_i` has no effect, and the burst continues until it is terminated or restarted.
- R7: A `term_i` sampled high during a burst makes `valid_o` low on the next cycle. While the block is idle, `term_i` has no effect. A `start_i` sampled together with `term_i` starts the new burst.
- R8: A `start_i` sampled during a running burst abandons the rest of that burst. It presents the new burst's first beat on the next cycle.
- R9: `last_o` is high exactly on the final beat of a 1-, 2-, 4- or 8-beat burst. It is never high in full-page mode or while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new burst with the fields below |
| start_col_i | input | 8 | First column of the burst |
| blen_i | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 4..7=full page |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench starts bursts whose start column sits in the middle or at the top of an aligned block. A generator that adds without masking would then carry into the upper bits, and one that confused the two orderings would produce swapped beats. It runs a full-page burst across the 255-to-0 boundary, and one longer than 256 beats, to catch a counter that saturates or sets `last_o` when it wraps. Back-to-back and overlapping starts, a stop request with no burst running, and a stop request that arrives together with a start expose designs that lose a beat, let a finished burst run on, or give the stop request priority over the new start.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W  = 8;
    localparam int LEN_W  = 3;
    localparam int FIXED_CODES = 4;   // codes below this select 1,2,4,8 beats

    typedef logic [COL_W-1:0] col_t;
    typedef logic [LEN_W-1:0] len_code_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        col_t   origin;     // column supplied with the command
        col_t   wrap_mask;  // low bits that move during the burst
        order_e order;
        logic   open_end;   // full page: no natural end
    } burst_cfg_t;

    // Mask of the bits that change inside the aligned burst window.
    function automatic col_t mask_for(input len_code_t code);
        col_t one;
        one = col_t'(1);
        if (int'(code) >= FIXED_CODES)
            return '1;
        return (one << code) - one;
    endfunction

    function automatic burst_cfg_t make_cfg(input col_t col,
                                            input len_code_t code,
                                            input logic ord);
        burst_cfg_t c;
        c.origin    = col;
        c.wrap_mask = mask_for(code);
        c.open_end  = (int'(code) >= FIXED_CODES);
        c.order     = (ord && !c.open_end) ? ORD_XOR : ORD_SEQ;
        return c;
    endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_col_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       term_i,
    input  burst_cfg_t cfg_i,
    output burst_cfg_t cfg_q,
    output col_t       beat_q,
    output logic       active_q,
    output logic       final_o
);

    logic at_end;

    // A fixed burst ends when the beat index has filled the window mask.
    assign at_end  = active_q && !cfg_q.open_end && (beat_q == cfg_q.wrap_mask);
    assign final_o = at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            cfg_q    <= cfg_i;
        end else if (active_q) begin
            if (term_i || at_end) begin
                active_q <= 1'b0;
                beat_q   <= '0;
            end else begin
                beat_q   <= beat_q + col_t'(1);   // wraps freely in full page
            end
        end
    end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_col_pkg::*;
(
    input  burst_cfg_t cfg_i,
    input  col_t       beat_i,
    output col_t       col_o
);

    col_t stepped;
    col_t mixed;

    assign stepped = cfg_i.origin + beat_i;
    assign mixed   = cfg_i.origin ^ beat_i;

    // Per bit: bits outside the window hold the origin, bits inside follow the order.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!cfg_i.wrap_mask[b])
                col_o[b] = cfg_i.origin[b];
            else if (cfg_i.order == ORD_XOR)
                col_o[b] = mixed[b];
            else
                col_o[b] = stepped[b];
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] start_col_i,
    input  logic [2:0] blen_i,
    input  logic       btype_i,
    input  logic       term_i,
    output logic [7:0] col_o,
    output logic       valid_o,
    output logic       last_o
);

    burst_cfg_t cfg_new;
    burst_cfg_t cfg_cur;
    col_t       beat;
    col_t       col_raw;
    logic       active;
    logic       final_beat;

    assign cfg_new = make_cfg(start_col_i, blen_i, btype_i);

    burst_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .term_i   (term_i),
        .cfg_i    (cfg_new),
        .cfg_q    (cfg_cur),
        .beat_q   (beat),
        .active_q (active),
        .final_o  (final_beat)
    );

    burst_col_map u_map (
        .cfg_i  (cfg_cur),
        .beat_i (beat),
        .col_o  (col_raw)
    );

    assign valid_o = active;
    assign last_o  = final_beat;
    assign col_o   = active ? col_raw : '0;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [7:0] start_col_i,
    input logic [2:0] blen_i,
    input logic       btype_i,
    input logic       term_i,
    input logic [7:0] col_o,
    input logic       valid_o,
    input logic       last_o
);

    logic       full_seen;
    logic [7:0] hold_mask;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_seen <= 1'b0;
            hold_mask <= '0;
            armed     <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (start_i) begin
                full_seen <= (blen_i >= 3'd4);
                hold_mask <= (blen_i >= 3'd4) ? 8'hFF : ((8'd1 << blen_i) - 8'd1);
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!valid_o && !last_o));

    // R2
    start_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R5
    end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    // R5
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !term_i && !start_i) |=> valid_o);

    // R7
    term_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !valid_o);

    // R9
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R9
    no_last_full_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && valid_o && full_seen) |-> !last_o);

    // R3
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !start_i && !term_i && !last_o) |=>
            ((col_o & ~hold_mask) == ($past(col_o) & ~hold_mask)));

endmodule

bind burst_col_gen burst_col_gen_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .btype_i     (btype_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       btype_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit monitoring = 0;

    logic [8:0] exp_q[$];   // {last, col}
    string      tag_q[$];

    always #5 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .btype_i(btype_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic logic [8:0] expect_beat(input logic [7:0] s, input int code,
                                               input bit ilv, input int k);
        int bl;
        int low;
        logic [7:0] c;
        if (code >= 4) begin
            c = 8'((int'(s) + k) % 256);
            return {1'b0, c};
        end
        bl  = 1 << code;
        low = int'(s) % bl;
        if (ilv) low = low ^ k;
        else     low = (low + k) % bl;
        c = 8'((int'(s) / bl) * bl + low);
        return {(k == bl - 1), c};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (monitoring && !done) begin
            if (valid_o) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5/R7: beat col=%02h last=%0b, expected no beat", col_o, last_o);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({last_o, col_o} !== e) begin
                        errors++;
                        $display("FAIL %s: col=%02h last=%0b, expected col=%02h last=%0b",
                                 t, col_o, last_o, e[7:0], e[8]);
                    end
                end
            end else if (last_o) begin
                checks++;
                errors++;
                $display("FAIL R9: last_o=1 with valid_o=0, expected 0");
            end
        end
    end

    // Driver: called at a negedge; returns at a negedge where beat n-1 is visible.
    task automatic burst(input logic [7:0] s, input int code, input bit ilv,
                         input int n, input bit stop, input bit term_with_start,
                         input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(expect_beat(s, code, ilv, k));
            tag_q.push_back(tag);
        end
        start_i = 1'b1; start_col_i = s; blen_i = 3'(code); btype_i = ilv;
        term_i = term_with_start;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        repeat (n - 1) @(negedge clk);
        if (stop) begin
            term_i = 1'b1;
            @(negedge clk);
            term_i = 1'b0;
        end
    endtask

    task automatic idle(input int n, input bit poke_term, input string tag);
        term_i = poke_term;
        @(negedge clk);
        term_i = 1'b0;
        repeat (n) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d beats missing, expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (valid_o !== 1'b0 || last_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%0b last=%0b, expected 0 0", valid_o, last_o);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;   // R1 after reset
        if (valid_o !== 1'b0 || last_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%0b last=%0b after reset, expected 0 0", valid_o, last_o);
        end
        monitoring = 1;

        // R2 R3 R5 R9: sequential fixed lengths, back to back
        burst(8'h1D, 3, 0, 8, 0, 0, "R3");
        burst(8'h47, 2, 0, 4, 0, 0, "R3");
        burst(8'hFF, 1, 0, 2, 0, 0, "R5");
        burst(8'h80, 0, 0, 1, 0, 0, "R9");
        idle(2, 0, "R5");
        // R4: interleaved
        burst(8'h35, 3, 1, 8, 0, 0, "R4");
        burst(8'h06, 2, 1, 4, 0, 0, "R4");
        burst(8'h13, 1, 1, 2, 0, 0, "R4");
        idle(2, 0, "R4");
        // R7: term while idle is ignored
        idle(3, 1, "R7");
        // R6: full page across 255->0, ordering ignored, then stopped
        burst(8'd250, 4, 1, 10, 1, 0, "R6");
        idle(2, 0, "R6");
        // R6: longer than a page
        burst(8'd5, 6, 0, 300, 1, 0, "R6");
        idle(2, 0, "R6");
        // R8: abort fixed burst, abort full page
        burst(8'h20, 3, 0, 3, 0, 0, "R8");
        burst(8'h92, 2, 0, 4, 0, 0, "R8");
        burst(8'd7, 4, 0, 5, 0, 0, "R8");
        burst(8'h44, 0, 1, 1, 0, 0, "R8");
        idle(2, 0, "R8");
        // R7: start together with term wins
        burst(8'hC0, 7, 0, 4, 0, 0, "R7");
        burst(8'h31, 1, 0, 2, 0, 1, "R7");
        idle(2, 0, "R7");
        // R7: term mid fixed burst
        burst(8'h58, 3, 0, 3, 1, 0, "R7");
        idle(2, 0, "R7");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

endmodule